// File: doc/BRIEF.md
# Bitfield extract, insert and align unit

This block is a single-stage execution unit for 32-bit bit manipulation. It takes three source words and a 3-bit operation code, and returns one of five results: a bitfield pulled out of the first source, either zero-filled or sign-filled above the field; the first source used as a select mask to merge the second and third sources bit by bit; or a right funnel shift of the first and second sources joined into a 64-bit word, with the shift counted in bits or in whole bytes.

The caller raises `valid_i` with the operands and the operation code for one cycle. On the next rising clock edge, the result and `valid_o` appear together. The result register loads only on accepted cycles, so between operations the output keeps the last result. The shift counts, field offsets and field lengths are taken modulo the word width, so any operand value is legal.

Top module: `bitx_unit`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0 and `result_o` is 0.
- R2: `valid_o` in each cycle equals `valid_i` of the previous cycle. The result for an operation accepted with `valid_i` high is on `result_o` one clock later.
- R3: When `valid_i` is low, `result_o` keeps its previous value whatever the other inputs do.
- R4: Op code 0 (unsigned extract) uses offset `b_i[4:0]` and length `c_i[4:0]`. A length of 0 gives 0. If offset + length < 32, the result is `a_i[offset+length-1:offset]` zero-extended. Otherwise it is `a_i` logically shifted right by the offset.
- R5: Op code 1 (signed extract) uses the same offset, length and zero-length rule. If offset + length < 32, the field is sign-extended from its top bit. Otherwise the result is `a_i` arithmetically shifted right by the offset.
- R6: Op code 2 (masked insert) gives `(a_i & b_i) | (~a_i & c_i)`. Each set bit of `a_i` takes the bit from `b_i`, and each clear bit takes it from `c_i`.
- R7: Op code 3 (bit align) gives the low 32 bits of `{a_i, b_i}` shifted right by `c_i[4:0]`.
- R8: Op code 4 (byte align) gives the low 32 bits of `{a_i, b_i}` shifted right by `8 * c_i[1:0]`.
- R9: Op codes 5, 6 and 7 give a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and op code are valid this cycle |
| op_i | input | 3 | Operation code (0..4 used) |
| a_i | input | 32 | First source: extract source, insert mask, align high half |
| b_i | input | 32 | Second source: extract offset, insert data, align low half |
| c_i | input | 32 | Third source: extract length, insert background, align count |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| result_o | output | 32 | Registered result |

## Verification
In the extract operations, the zero-filled field rule and the whole-word shift rule meet where offset plus length equals exactly 32. The bench aims directed cases at that boundary and just below it, in both signed and unsigned form, including a field whose top bit is set. Random operands then reach both rules many times in a run. A second pair of behaviours shares a cycle when an operation is issued back-to-back: the new result is captured while the previous one is still being presented. Idle cycles with changing operands are inserted so that the bench can check that the output holds. Each result is compared with a bit-by-bit model of the requirement.

// File: rtl/bitx_pkg.sv
package bitx_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_EXT_U      = 3'd0,
    OP_EXT_S      = 3'd1,
    OP_INSERT     = 3'd2,
    OP_ALIGN_BIT  = 3'd3,
    OP_ALIGN_BYTE = 3'd4
  } bitx_op_e;
endpackage

// File: rtl/bitx_extract.sv
module bitx_extract #(
  parameter int unsigned W      = 32,
  parameter bit          SIGNED = 1'b0,
  localparam int unsigned AW    = $clog2(W)
) (
  input  logic [W-1:0]  src_i,
  input  logic [AW-1:0] off_i,
  input  logic [AW-1:0] len_i,
  output logic [W-1:0]  res_o
);
  logic [AW:0]  sum;
  logic [AW:0]  up_sh;
  logic [AW:0]  dn_sh;
  logic         overrun;
  logic [W-1:0] shl;
  logic [W-1:0] field;
  logic [W-1:0] tail;

  assign sum     = {1'b0, off_i} + {1'b0, len_i};
  assign overrun = sum[AW];
  assign up_sh   = (AW+1)'(W) - sum;
  assign dn_sh   = (AW+1)'(W) - {1'b0, len_i};
  assign shl     = src_i << up_sh;

  generate
    if (SIGNED) begin : g_arith
      assign field = W'($signed(shl) >>> dn_sh);
      assign tail  = W'($signed(src_i) >>> off_i);
    end else begin : g_logic
      assign field = shl >> dn_sh;
      assign tail  = src_i >> off_i;
    end
  endgenerate

  always_comb begin
    if (len_i == '0)   res_o = '0;
    else if (overrun)  res_o = tail;
    else               res_o = field;
  end
endmodule

// File: rtl/bitx_funnel.sv
module bitx_funnel #(
  parameter int unsigned W         = 32,
  parameter bit          BYTE_STEP = 1'b0,
  localparam int unsigned AW       = $clog2(W),
  localparam int unsigned BW       = $clog2(W/8),
  localparam int unsigned SW       = BYTE_STEP ? BW : AW
) (
  input  logic [W-1:0]  hi_i,
  input  logic [W-1:0]  lo_i,
  input  logic [SW-1:0] amt_i,
  output logic [W-1:0]  res_o
);
  logic [AW-1:0]  sh;
  logic [2*W-1:0] joined;
  logic [2*W-1:0] shifted;

  generate
    if (BYTE_STEP) begin : g_byte
      assign sh = {amt_i, 3'b000};
    end else begin : g_bit
      assign sh = amt_i;
    end
  endgenerate

  assign joined  = {hi_i, lo_i};
  assign shifted = joined >> sh;
  assign res_o   = shifted[W-1:0];
endmodule

// File: rtl/bitx_unit.sv
module bitx_unit
  import bitx_pkg::*;
#(
  parameter int unsigned W  = 32,
  localparam int unsigned AW = $clog2(W),
  localparam int unsigned BW = $clog2(W/8)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic [W-1:0]    c_i,
  output logic            valid_o,
  output logic [W-1:0]    result_o
);
  logic [W-1:0] ext_u, ext_s, ins, aln_bit, aln_byte, res_d;

  bitx_extract #(.W(W), .SIGNED(1'b0)) u_ext_u (
    .src_i(a_i), .off_i(b_i[AW-1:0]), .len_i(c_i[AW-1:0]), .res_o(ext_u)
  );

  bitx_extract #(.W(W), .SIGNED(1'b1)) u_ext_s (
    .src_i(a_i), .off_i(b_i[AW-1:0]), .len_i(c_i[AW-1:0]), .res_o(ext_s)
  );

  // a_i selects b_i where set, c_i where clear
  assign ins = (a_i & b_i) | (~a_i & c_i);

  bitx_funnel #(.W(W), .BYTE_STEP(1'b0)) u_aln_bit (
    .hi_i(a_i), .lo_i(b_i), .amt_i(c_i[AW-1:0]), .res_o(aln_bit)
  );

  bitx_funnel #(.W(W), .BYTE_STEP(1'b1)) u_aln_byte (
    .hi_i(a_i), .lo_i(b_i), .amt_i(c_i[BW-1:0]), .res_o(aln_byte)
  );

  always_comb begin
    case (op_i)
      OP_EXT_U:      res_d = ext_u;
      OP_EXT_S:      res_d = ext_s;
      OP_INSERT:     res_d = ins;
      OP_ALIGN_BIT:  res_d = aln_bit;
      OP_ALIGN_BYTE: res_d = aln_byte;
      default:       res_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= res_d;
    end
  end
endmodule

// File: rtl/bitx_unit_chk.sv
module bitx_unit_chk #(
  parameter int unsigned W  = 32,
  localparam int unsigned AW = $clog2(W)
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [2:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] c_i,
  input logic         valid_o,
  input logic [W-1:0] result_o
);
  always @(posedge clk_i) begin
    if (rst_ni === 1'b0) begin
      p_reset_clear_r1: assert (valid_o == 1'b0 && result_o == '0)
        else $error("reset state not clear");
    end
  end

  p_valid_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_valid_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));

  p_zero_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i <= 3'd1 && c_i[AW-1:0] == '0) |=> result_o == '0);

  p_insert_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd2) |=>
      result_o == (($past(a_i) & $past(b_i)) | (~$past(a_i) & $past(c_i))));

  p_unused_op_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i > 3'd4) |=> result_o == '0);
endmodule

bind bitx_unit bitx_unit_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
  .a_i(a_i), .b_i(b_i), .c_i(c_i), .valid_o(valid_o), .result_o(result_o)
);

// File: tb/sim_bitx_unit.sv
`timescale 1ns/1ps
module sim_bitx_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [31:0] a_i = '0, b_i = '0, c_i = '0;
  logic        valid_o;
  logic [31:0] result_o;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk_i = ~clk_i;

  bitx_unit u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .c_i(c_i), .valid_o(valid_o), .result_o(result_o)
  );

  // bit-by-bit field model
  function automatic logic [31:0] ref_extract(logic [31:0] a, logic [31:0] b,
                                               logic [31:0] c, bit sgn);
    int off = int'(b[4:0]);
    int len = int'(c[4:0]);
    int top;
    int cnt;
    logic [31:0] r = '0;
    if (len == 0) return '0;
    top = (off + len < 32) ? off + len - 1 : 31;
    cnt = top - off + 1;
    for (int i = 0; i < 32; i++) begin
      if (i < cnt) r[i] = a[off + i];
      else         r[i] = sgn ? a[top] : 1'b0;
    end
    return r;
  endfunction

  function automatic logic [31:0] ref_funnel(logic [31:0] hi, logic [31:0] lo, int sh);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      if (i + sh < 32) r[i] = lo[i + sh];
      else             r[i] = hi[i + sh - 32];
    end
    return r;
  endfunction

  function automatic logic [31:0] ref_op(logic [2:0] op, logic [31:0] a,
                                         logic [31:0] b, logic [31:0] c);
    case (op)
      3'd0: return ref_extract(a, b, c, 1'b0);
      3'd1: return ref_extract(a, b, c, 1'b1);
      3'd2: begin
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = a[i] ? b[i] : c[i];
        return r;
      end
      3'd3: return ref_funnel(a, b, int'(c[4:0]));
      3'd4: return ref_funnel(a, b, 8 * int'(c[1:0]));
      default: return '0;
    endcase
  endfunction

  function automatic string req_of(logic [2:0] op);
    case (op)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  // drive at negedge, sample at next negedge (one register stage)
  task automatic issue(logic [2:0] op, logic [31:0] a, logic [31:0] b, logic [31:0] c);
    logic [31:0] exp;
    exp = ref_op(op, a, b, c);
    op_i = op; a_i = a; b_i = b; c_i = c; valid_i = 1'b1;
    @(negedge clk_i);
    check("R2", {31'd0, valid_o}, 32'd1);
    check(req_of(op), result_o, exp);
  endtask

  task automatic idle_hold(logic [31:0] held);
    op_i = 3'd2; a_i = $urandom; b_i = $urandom; c_i = $urandom; valid_i = 1'b0;
    @(negedge clk_i);
    check("R2", {31'd0, valid_o}, 32'd0);
    check("R3", result_o, held);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk_i);
    // R1 reset state
    check("R1", {31'd0, valid_o}, 32'd0);
    check("R1", result_o, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R4 / R5 directed corners
    issue(3'd0, 32'hDEADBEEF, 32'd4, 32'd0);            // zero length
    issue(3'd1, 32'hDEADBEEF, 32'd4, 32'h20);           // length masks to 0
    issue(3'd0, 32'hF0F0_0F00, 32'd8, 32'd4);           // field below top
    issue(3'd1, 32'h0000_0F00, 32'd8, 32'd4);           // negative field sign-extends
    issue(3'd1, 32'h0000_0700, 32'd8, 32'd4);           // positive field
    issue(3'd0, 32'h8000_0001, 32'd16, 32'd16);         // off+len == 32 exactly
    issue(3'd1, 32'h8000_0001, 32'd16, 32'd16);
    issue(3'd1, 32'h8000_0001, 32'd16, 32'd15);         // just below boundary
    issue(3'd0, 32'hFFFF_FFFF, 32'd31, 32'd31);         // overrun
    issue(3'd1, 32'h8000_0000, 32'd31, 32'd31);
    issue(3'd1, 32'h8000_0000, 32'hFFFF_FFE3, 32'd2);   // offset masked to 3
    // R6
    issue(3'd2, 32'hFF00_FF00, 32'h1234_5678, 32'h9ABC_DEF0);
    // R7
    issue(3'd3, 32'hAAAA_5555, 32'h1357_9BDF, 32'd0);
    issue(3'd3, 32'hAAAA_5555, 32'h1357_9BDF, 32'd31);
    issue(3'd3, 32'hAAAA_5555, 32'h1357_9BDF, 32'h21);  // masks to 1
    // R8
    for (int k = 0; k < 4; k++) issue(3'd4, 32'h0102_0304, 32'h0506_0708, 32'(k) | 32'h1C);
    // R9
    for (int k = 5; k < 8; k++) issue(3'(k), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    // R3 hold after a nonzero result
    issue(3'd2, 32'h0000_FFFF, 32'hCAFE_BABE, 32'h1111_1111);
    idle_hold(32'h1111_BABE);
    idle_hold(32'h1111_BABE);

    // random back-to-back with occasional idles
    for (int n = 0; n < 3000; n++) begin
      logic [2:0]  op;
      logic [31:0] a, b, c, keep;
      op = 3'($urandom_range(0, 7));
      a = $urandom; b = $urandom; c = $urandom;
      if (($urandom & 3) == 0) c[4:0] = 5'(32 - int'(b[4:0]));
      issue(op, a, b, c);
      if (($urandom & 7) == 0) begin
        keep = ref_op(op, a, b, c);
        idle_hold(keep);
      end
    end

    valid_i = 1'b0;
    @(negedge clk_i);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule